// File: doc/BRIEF.md
# Status Flag Bank with Break-Guarded Two-Step Clearing

This block holds a small bank of peripheral status flags. Each flag is raised by a single-cycle hardware event pulse and stays raised until software clears it in two steps. First, software reads the status register while the flag is up, and the block records that the read took place. Later, software writes a zero to that flag's bit position. A write of zero to a flag whose read was not recorded leaves the flag untouched, so a flag that rises after software last looked at it is never lost.

A debug break input freezes this protocol. While the break is active, register reads and writes reach the flags only if a break-clear-enable control bit, which software loads through its own strobe, has been set. That control bit comes up cleared out of reset. In that default setting, a debugger can inspect and write the register during a break without disturbing any flag. A read recorded before the break is still honoured by the first zero-write after the break ends.

Top module: `flag_clear_top`

## Requirements
- R1: Reset clears every flag, every recorded read and the break-clear-enable bit, so after reset all flags read 0 and break-time accesses are blocked.
- R2: An event pulse on bit i sets flag i at the next clock edge, and the flag then holds without further events.
- R3: A read strobe while flag i is 1 (outside a break, or with break-clear-enable 1) records a read for bit i. A later write strobe with data bit i = 0 then clears flag i at the next edge.
- R4: A write of 0 to a flag with no recorded read leaves the flag at 1. A read taken while the flag was 0 does not count.
- R5: Writing 1 to a flag bit changes neither the flag nor its recorded read.
- R6: With break-clear-enable 0 and the break input high, read and write strobes have no effect. The flag keeps its value, and a read taken then is not recorded.
- R7: A read recorded before a break survives a break with break-clear-enable 0. The first zero-write after the break ends clears the flag.
- R8: With break-clear-enable 1, a read and a zero-write during a break clear the flag, and the flag stays 0 after the break ends.
- R9: If an event on bit i arrives in the same cycle as an accepted zero-write to an armed bit i, the flag stays 1 and its recorded read is dropped, so a fresh read is needed to clear it.
- R10: Flag bits are independent. A write clears exactly the armed bits whose data bit is 0.
- R11: A strobe on the enable-write input loads the break-clear-enable bit from its data input. Loading 0 again blocks break-time clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| eventIn | input | NUM_FLAGS | Per-flag hardware set pulses |
| rdStb | input | 1 | Status register read strobe |
| wrStb | input | 1 | Status register write strobe |
| wrData | input | NUM_FLAGS | Write data; bit i = 0 requests clearing flag i |
| breakActive | input | 1 | Debug break in progress |
| bcfeWr | input | 1 | Load strobe for the break-clear-enable bit |
| bcfeData | input | 1 | Value loaded into the break-clear-enable bit |
| flagOut | output | NUM_FLAGS | Current flag values (also the read data) |

## Verification
Each flag has a hidden recorded-read bit. A wrong value in it does not show when it goes wrong. It shows at the next zero-write to that bit: a spurious arm drops a flag one cycle after a write that should have been ignored, and a lost arm leaves a flag stuck after a write that should have cleared it. A wrong break-clear-enable bit shows only while the break input is high, as a flag that clears or fails to clear one cycle after a break-time write. Each scenario therefore pairs a read with a write and samples flagOut one cycle after the write, both inside and after the break.

// File: rtl/flag_clear_pkg.sv
package flag_clear_pkg;

  // Register accesses that survived break gating, handed from control to datapath.
  typedef struct packed {
    logic rdTake;
    logic wrTake;
  } accStrobe_t;

endpackage

// File: rtl/flag_clear_ctrl.sv
module flag_clear_ctrl
  import flag_clear_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdStb,
  input  logic       wrStb,
  input  logic       breakActive,
  input  logic       bcfeWr,
  input  logic       bcfeData,
  output accStrobe_t strb,
  output logic       bcfeQ
);

  logic accessOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       bcfeQ <= 1'b0;
    else if (bcfeWr) bcfeQ <= bcfeData;
  end

  // Software accesses count unless a break is active with clearing disabled.
  assign accessOk = !breakActive || bcfeQ;

  always_comb begin
    strb.rdTake = rdStb && accessOk;
    strb.wrTake = wrStb && accessOk;
  end

endmodule

// File: rtl/flag_clear_dp.sv
module flag_clear_dp
  import flag_clear_pkg::*;
#(
  parameter int NUM_FLAGS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  accStrobe_t           strb,
  input  logic [NUM_FLAGS-1:0] eventIn,
  input  logic [NUM_FLAGS-1:0] wrData,
  output logic [NUM_FLAGS-1:0] flagQ,
  output logic [NUM_FLAGS-1:0] armedQ
);

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_bit
    logic clrHit;

    // Second step: a zero written to a bit whose read was recorded.
    assign clrHit = strb.wrTake && !wrData[i] && armedQ[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flagQ[i]  <= 1'b0;
        armedQ[i] <= 1'b0;
      end else begin
        // A new event wins over a clear in the same cycle.
        if (eventIn[i])  flagQ[i] <= 1'b1;
        else if (clrHit) flagQ[i] <= 1'b0;

        // The arm is used up by any accepted clear, even one that loses to an event.
        if (clrHit)                         armedQ[i] <= 1'b0;
        else if (strb.rdTake && flagQ[i])   armedQ[i] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/flag_clear_top.sv
module flag_clear_top
  import flag_clear_pkg::*;
#(
  parameter int NUM_FLAGS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_FLAGS-1:0] eventIn,
  input  logic                 rdStb,
  input  logic                 wrStb,
  input  logic [NUM_FLAGS-1:0] wrData,
  input  logic                 breakActive,
  input  logic                 bcfeWr,
  input  logic                 bcfeData,
  output logic [NUM_FLAGS-1:0] flagOut
);

  accStrobe_t           strb;
  logic                 bcfeQ;
  logic [NUM_FLAGS-1:0] armedQ;

  flag_clear_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .rdStb       (rdStb),
    .wrStb       (wrStb),
    .breakActive (breakActive),
    .bcfeWr      (bcfeWr),
    .bcfeData    (bcfeData),
    .strb        (strb),
    .bcfeQ       (bcfeQ)
  );

  flag_clear_dp #(.NUM_FLAGS(NUM_FLAGS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .eventIn (eventIn),
    .wrData  (wrData),
    .flagQ   (flagOut),
    .armedQ  (armedQ)
  );

endmodule

// File: rtl/flag_clear_chk.sv
module flag_clear_chk #(
  parameter int NUM_FLAGS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_FLAGS-1:0] eventIn,
  input logic                 wrStb,
  input logic [NUM_FLAGS-1:0] wrData,
  input logic                 breakActive,
  input logic                 bcfeQ,
  input logic [NUM_FLAGS-1:0] armedQ,
  input logic [NUM_FLAGS-1:0] flagOut
);

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_chk
    p_event_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
      eventIn[i] |=> flagOut[i]);

    p_fall_needs_arm_r3: assert property (@(posedge clk) disable iff (!rstN)
      $fell(flagOut[i]) |->
        $past(wrStb && !wrData[i] && armedQ[i] && !eventIn[i] && (!breakActive || bcfeQ)));

    p_armed_has_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
      armedQ[i] |-> flagOut[i]);

    p_break_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
      (breakActive && !bcfeQ && !eventIn[i]) |=> ($stable(flagOut[i]) && $stable(armedQ[i])));

    p_collision_r9: assert property (@(posedge clk) disable iff (!rstN)
      (eventIn[i] && wrStb && !wrData[i] && armedQ[i] && (!breakActive || bcfeQ))
        |=> (flagOut[i] && !armedQ[i]));
  end

endmodule

bind flag_clear_top flag_clear_chk #(.NUM_FLAGS(NUM_FLAGS)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .eventIn     (eventIn),
  .wrStb       (wrStb),
  .wrData      (wrData),
  .breakActive (breakActive),
  .bcfeQ       (bcfeQ),
  .armedQ      (armedQ),
  .flagOut     (flagOut)
);

// File: tb/tb_flag_clear_top.sv
`timescale 1ns/1ps
module tb_flag_clear_top;

  localparam int NF = 4;

  logic          clk = 1'b0;
  logic          rstN;
  logic [NF-1:0] eventIn;
  logic          rdStb;
  logic          wrStb;
  logic [NF-1:0] wrData;
  logic          breakActive;
  logic          bcfeWr;
  logic          bcfeData;
  logic [NF-1:0] flagOut;

  int nCmp = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  flag_clear_top #(.NUM_FLAGS(NF)) dut (
    .clk(clk), .rstN(rstN), .eventIn(eventIn), .rdStb(rdStb), .wrStb(wrStb),
    .wrData(wrData), .breakActive(breakActive), .bcfeWr(bcfeWr),
    .bcfeData(bcfeData), .flagOut(flagOut)
  );

  task automatic check(input string req, input logic [NF-1:0] exp);
    nCmp++;
    if (flagOut !== exp) begin
      nBad++;
      $display("FAIL %s: flagOut actual %b expected %b", req, flagOut, exp);
    end
  endtask

  // Inputs change at the falling edge; results are sampled one falling edge later.
  task automatic idle();
    @(negedge clk);
  endtask

  task automatic raise(input logic [NF-1:0] ev);
    eventIn = ev; @(negedge clk); eventIn = '0;
  endtask

  task automatic doRead();
    rdStb = 1'b1; @(negedge clk); rdStb = 1'b0;
  endtask

  task automatic doWrite(input logic [NF-1:0] d, input logic [NF-1:0] ev);
    wrStb = 1'b1; wrData = d; eventIn = ev;
    @(negedge clk);
    wrStb = 1'b0; wrData = '1; eventIn = '0;
  endtask

  task automatic setBcfe(input logic v);
    bcfeWr = 1'b1; bcfeData = v; @(negedge clk); bcfeWr = 1'b0;
  endtask

  task automatic testReset();
    check("R1", '0);
    rstN = 1'b1;
    idle();
    check("R1", '0);
  endtask

  task automatic testBreakBlocked();
    raise(4'b0001);
    breakActive = 1'b1;            // enable bit still at its reset value 0 (R1)
    doRead();
    doWrite(4'b0000, '0);
    check("R6", 4'b0001);
    breakActive = 1'b0;
    doWrite(4'b0000, '0);          // read in break was not recorded
    check("R6", 4'b0001);
    doRead();
    doWrite(4'b0000, '0);
    check("R3", 4'b0000);
  endtask

  task automatic testEventHold();
    raise(4'b0100);
    check("R2", 4'b0100);
    repeat (3) idle();
    check("R2", 4'b0100);
  endtask

  task automatic testNoArm();
    doWrite(4'b0000, '0);
    check("R4", 4'b0100);
    doRead(); doWrite(4'b0000, '0);
    check("R3", 4'b0000);
    doRead();                      // flag is 0 here: must not arm
    raise(4'b0100);
    doWrite(4'b0000, '0);
    check("R4", 4'b0100);
    doRead(); doWrite(4'b0000, '0);
    check("R4", 4'b0000);
  endtask

  task automatic testWriteOne();
    raise(4'b0010);
    doRead();
    doWrite(4'b1111, '0);
    check("R5", 4'b0010);
    doWrite(4'b0000, '0);          // arm survived the write of 1
    check("R5", 4'b0000);
  endtask

  task automatic testArmAcrossBreak();
    raise(4'b0010);
    doRead();
    breakActive = 1'b1;
    doWrite(4'b0000, '0);
    check("R7", 4'b0010);
    idle();
    check("R7", 4'b0010);
    breakActive = 1'b0;
    doWrite(4'b0000, '0);
    check("R7", 4'b0000);
  endtask

  task automatic testBreakEnabled();
    setBcfe(1'b1);
    raise(4'b1000);
    breakActive = 1'b1;
    doRead();
    doWrite(4'b0000, '0);
    check("R8", 4'b0000);
    breakActive = 1'b0;
    idle();
    check("R8", 4'b0000);
  endtask

  task automatic testCollision();
    raise(4'b0001);
    doRead();
    doWrite(4'b0000, 4'b0001);
    check("R9", 4'b0001);
    doWrite(4'b0000, '0);          // arm was consumed
    check("R9", 4'b0001);
    doRead(); doWrite(4'b0000, '0);
    check("R9", 4'b0000);
  endtask

  task automatic testIndependent();
    raise(4'b0101);
    doRead();
    doWrite(4'b1011, '0);
    check("R10", 4'b0001);
    doRead(); doWrite(4'b0000, '0);
    check("R10", 4'b0000);
  endtask

  task automatic testEnableReload();
    setBcfe(1'b0);
    raise(4'b0001);
    doRead();
    breakActive = 1'b1;
    doRead();
    doWrite(4'b0000, '0);
    check("R11", 4'b0001);
    breakActive = 1'b0;
    doWrite(4'b0000, '0);
    check("R11", 4'b0000);
  endtask

  initial begin
    rstN = 1'b0; eventIn = '0; rdStb = 1'b0; wrStb = 1'b0; wrData = '1;
    breakActive = 1'b0; bcfeWr = 1'b0; bcfeData = 1'b0;
    repeat (3) @(negedge clk);
    testReset();
    testBreakBlocked();
    testEventHold();
    testNoArm();
    testWriteOne();
    testArmAcrossBreak();
    testBreakEnabled();
    testCollision();
    testIndependent();
    testEnableReload();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule